// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Router

This block is the register front end of an expansion card that carries two IDE channels behind one host byte bus. It decodes each host access into one of several targets: a per-channel taskfile window (passed on as a chip-select and a register index), a per-channel alternate-status window, a per-channel interrupt enable latch, a per-channel pending-status register, a four-bit board identity readout, and a configuration register. The configuration register steers the card's single DMA engine to one channel and opens the extended address region.

Each drive raises a level interrupt. The block synchronises both levels and combines them into one host interrupt line, gated by the enable latches. An enable latch is set by a write of any value to its address and cleared by a read of that same address. Software uses this to steer the shared interrupt to one channel at a time: it writes one channel's control address and reads the other's. The drive-side bus timing and the DMA transfer engine sit outside this block.

Top module: `ide_irq_router`

## Requirements
- R1: After reset, both enable latches are clear, the configuration register is 0 (`dma_chan`=0, `ext_win_en`=0) and `host_irq` is low even when both drive interrupts are high.
- R2: A write of any value to 0x2200 sets channel 0's enable latch, and a read of 0x2200 clears it. Address 0x3200 does the same for channel 1. Each latch changes only on an access to its own address. When a read and a write strobe hit the same latch in one cycle, the write wins. Reads of these addresses return 0x00.
- R3: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns that channel's pending level in bit 0 and zeros in bits 7..1, whatever the state of the enable latch. The read clears nothing.
- R4: A pending level follows its drive interrupt input through a two-flop synchroniser. A change applied between two clock edges becomes visible after the second rising edge that follows it, and not after the first.
- R5: `host_irq` is high exactly when some channel is both pending and enabled.
- R6: While a strobe is active, an address in 0x2000..0x21FF asserts `tf_cs[0]` and an address in 0x3000..0x31FF asserts `tf_cs[1]`, with `tf_idx` = address bits [8:6]. At most one bit of `tf_cs` is set. Both bits are low with no strobe.
- R7: While a strobe is active, address 0x2380 asserts `alt_cs[0]` and 0x3380 asserts `alt_cs[1]`. No access asserts `alt_cs` and `tf_cs` together.
- R8: Reads of 0x2280, 0x2284, 0x2288 and 0x228C return identity bits 0, 1, 2 and 3 respectively in data bit 0. The default identity is 3.
- R9: The configuration register sits at address 0. Written bit 0 drives `dma_chan` (0 selects channel 0, 1 selects channel 1), written bit 5 drives `ext_win_en`, and the other written bits are dropped. A read returns only those two bits in place, and writing 0 clears both.
- R10: Reads of undecoded addresses, of taskfile windows and of alternate-status windows return 0x00 on `bus_rdata`. `bus_rdata` is 0x00 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Host byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| drv_irq | input | 2 | Level interrupt from each drive, asynchronous |
| host_irq | output | 1 | Combined interrupt to the host |
| tf_cs | output | 2 | Taskfile chip-select per channel |
| tf_idx | output | 3 | Taskfile register index |
| alt_cs | output | 2 | Alternate-status select per channel |
| dma_chan | output | 1 | Channel that owns the DMA engine |
| ext_win_en | output | 1 | Extended address region enable |

## Verification
The hardest state to reach from the ports is the enable latches. No register reads them back, and the read that would naturally inspect a latch clears it instead. The stimulus therefore holds a drive interrupt high so that the pending path is active, then watches `host_irq` after each enable access. The same method shows that a read of the other channel's control address leaves this channel's latch untouched, and that a simultaneous read and write ends with the latch set. The synchroniser delay is measured by moving a drive input between clock edges while the latch is set, then sampling `host_irq` after the first and after the second following edge.

// File: rtl/ide_irq_router_pkg.sv
package ide_irq_router_pkg;

    localparam int unsigned CH_N     = 2;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ID_BITS  = 4;
    localparam int unsigned ID_SEL_W = $clog2(ID_BITS);
    localparam int unsigned TF_IDX_W = 3;

    // one-hot-per-class decode of the current bus address
    typedef struct packed {
        logic                cfg;
        logic [CH_N-1:0]     ien;
        logic [CH_N-1:0]     stat;
        logic [CH_N-1:0]     alt;
        logic [CH_N-1:0]     tf;
        logic                id;
        logic [ID_SEL_W-1:0] id_bit;
    } hit_t;

    typedef struct packed {
        logic [CH_N-1:0]   en;
        logic [BYTE_W-1:0] cfg;
    } ctl_state_t;

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign level_out = stage_q[STAGES-1];

endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
    import ide_irq_router_pkg::*;
#(
    parameter int unsigned ADDR_W       = 14,
    parameter int unsigned CH0_BASE     = 'h2000,
    parameter int unsigned CH_STRIDE    = 'h1000,
    parameter int unsigned IEN_OFS      = 'h200,
    parameter int unsigned STAT_OFS     = 'h290,
    parameter int unsigned ALT_OFS      = 'h380,
    parameter int unsigned ID_OFS       = 'h280,
    parameter int unsigned ID_STEP      = 4,
    parameter int unsigned TF_SPAN_LOG2 = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);

    logic [CH_N-1:0]    ien_v, stat_v, alt_v, tf_v;
    logic [ID_BITS-1:0] id_v;

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH0_BASE + c * CH_STRIDE);
        assign ien_v[c]  = (addr == BASE + ADDR_W'(IEN_OFS));
        assign stat_v[c] = (addr == BASE + ADDR_W'(STAT_OFS));
        assign alt_v[c]  = (addr == BASE + ADDR_W'(ALT_OFS));
        assign tf_v[c]   = (addr[ADDR_W-1:TF_SPAN_LOG2] == BASE[ADDR_W-1:TF_SPAN_LOG2]);
    end

    for (genvar k = 0; k < ID_BITS; k++) begin : g_id
        assign id_v[k] = (addr == ADDR_W'(CH0_BASE + ID_OFS + k * ID_STEP));
    end

    always_comb begin
        hit        = '0;
        hit.cfg    = (addr == '0);
        hit.ien    = ien_v;
        hit.stat   = stat_v;
        hit.alt    = alt_v;
        hit.tf     = tf_v;
        hit.id     = |id_v;
        for (int k = 0; k < ID_BITS; k++) begin
            if (id_v[k]) hit.id_bit = ID_SEL_W'(k);
        end
    end

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import ide_irq_router_pkg::*;
#(
    parameter int unsigned DMA_BIT = 0,
    parameter int unsigned EXT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cfg_hit,
    input  logic [CH_N-1:0]   ien_hit,
    output logic [CH_N-1:0]   irq_en,
    output logic [BYTE_W-1:0] cfg_val
);

    localparam logic [BYTE_W-1:0] CFG_MASK = BYTE_W'((1 << DMA_BIT) | (1 << EXT_BIT));

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int c = 0; c < CH_N; c++) begin
            // a write outranks a read landing on the same latch
            if (bus_wr && ien_hit[c])      state_d.en[c] = 1'b1;
            else if (bus_rd && ien_hit[c]) state_d.en[c] = 1'b0;
        end
        if (bus_wr && cfg_hit) state_d.cfg = wdata & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_en  = state_q.en;
    assign cfg_val = state_q.cfg;

    for (genvar c = 0; c < CH_N; c++) begin : g_chk
        // R2
        en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && ien_hit[c]) |=> irq_en[c]);
        // R2
        en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && ien_hit[c]) |=> !irq_en[c]);
        // R2
        en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(ien_hit[c] && (bus_rd || bus_wr)) |=> $stable(irq_en[c]));
    end

    // R9
    cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cfg_hit) |=> (cfg_val == ($past(wdata) & CFG_MASK)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && cfg_hit) |=> $stable(cfg_val));

endmodule

// File: rtl/ide_irq_router.sv
module ide_irq_router
    import ide_irq_router_pkg::*;
#(
    parameter int unsigned        ADDR_W      = 14,
    parameter logic [ID_BITS-1:0] BOARD_ID    = 4'd3,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter int unsigned        DMA_BIT     = 0,
    parameter int unsigned        EXT_BIT     = 5,
    parameter int unsigned        TF_IDX_LSB  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [CH_N-1:0]     drv_irq,
    output logic                host_irq,
    output logic [CH_N-1:0]     tf_cs,
    output logic [TF_IDX_W-1:0] tf_idx,
    output logic [CH_N-1:0]     alt_cs,
    output logic                dma_chan,
    output logic                ext_win_en
);

    hit_t              hit;
    logic [CH_N-1:0]   pend;
    logic [CH_N-1:0]   irq_en;
    logic [BYTE_W-1:0] cfg_val;
    logic              strobe;
    logic [BYTE_W-1:0] rdata_c;

    bus_addr_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    irq_level_sync #(
        .WIDTH  (CH_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (drv_irq),
        .level_out (pend)
    );

    irq_ctl_regs #(
        .DMA_BIT (DMA_BIT),
        .EXT_BIT (EXT_BIT)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .wdata   (bus_wdata),
        .cfg_hit (hit.cfg),
        .ien_hit (hit.ien),
        .irq_en  (irq_en),
        .cfg_val (cfg_val)
    );

    assign strobe = bus_rd | bus_wr;

    always_comb begin
        rdata_c = '0;
        if (bus_rd) begin
            if (hit.cfg) rdata_c = cfg_val;
            for (int c = 0; c < CH_N; c++) begin
                if (hit.stat[c]) rdata_c = BYTE_W'(pend[c]);
            end
            if (hit.id) rdata_c = BYTE_W'(BOARD_ID[hit.id_bit]);
        end
    end

    assign bus_rdata  = rdata_c;
    assign host_irq   = |(pend & irq_en);
    assign tf_cs      = hit.tf & {CH_N{strobe}};
    assign alt_cs     = hit.alt & {CH_N{strobe}};
    assign tf_idx     = bus_addr[TF_IDX_LSB +: TF_IDX_W];
    assign dma_chan   = cfg_val[DMA_BIT];
    assign ext_win_en = cfg_val[EXT_BIT];

    // R6
    tf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tf_cs));

    // R7
    cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|tf_cs) && (|alt_cs)));

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/tb_ide_irq_router.sv
module tb_ide_irq_router;

    localparam int PERIOD = 10;
    localparam int NVEC   = 18;

    // [41] write, [40:27] addr, [26:19] wdata, [18:11] rdata, [10:9] tf_cs,
    // [8:6] tf_idx, [5:4] alt_cs, [3:0] requirement number
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b0, 14'h0000, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd9},  // R9 reset value
        {1'b1, 14'h0000, 8'hFF, 8'h00, 2'b00, 3'd0, 2'b00, 4'd9},  // R9 write all ones
        {1'b0, 14'h0000, 8'h00, 8'h21, 2'b00, 3'd0, 2'b00, 4'd9},  // R9 only bits 0,5 kept
        {1'b1, 14'h0000, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd9},  // R9 write zero
        {1'b0, 14'h0000, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd9},  // R9 cleared
        {1'b0, 14'h2280, 8'h00, 8'h01, 2'b00, 3'd0, 2'b00, 4'd8},  // R8 id bit 0
        {1'b0, 14'h2284, 8'h00, 8'h01, 2'b00, 3'd0, 2'b00, 4'd8},  // R8 id bit 1
        {1'b0, 14'h2288, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd8},  // R8 id bit 2
        {1'b0, 14'h228C, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd8},  // R8 id bit 3
        {1'b0, 14'h2000, 8'h00, 8'h00, 2'b01, 3'd0, 2'b00, 4'd6},  // R6 ch0 first reg
        {1'b1, 14'h2140, 8'h5A, 8'h00, 2'b01, 3'd5, 2'b00, 4'd6},  // R6 ch0 index 5
        {1'b0, 14'h31C0, 8'h00, 8'h00, 2'b10, 3'd7, 2'b00, 4'd6},  // R6 ch1 index 7
        {1'b0, 14'h3040, 8'h00, 8'h00, 2'b10, 3'd1, 2'b00, 4'd6},  // R6 ch1 index 1
        {1'b0, 14'h2380, 8'h00, 8'h00, 2'b00, 3'd0, 2'b01, 4'd7},  // R7 ch0 alt
        {1'b1, 14'h3380, 8'h0F, 8'h00, 2'b00, 3'd0, 2'b10, 4'd7},  // R7 ch1 alt
        {1'b0, 14'h2290, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd3},  // R3 nothing pending
        {1'b0, 14'h1234, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd10}, // R10 undecoded
        {1'b0, 14'h2281, 8'h00, 8'h00, 2'b00, 3'd0, 2'b00, 4'd10}  // R10 misaligned id
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  drv_irq = '0;
    logic        host_irq;
    logic [1:0]  tf_cs;
    logic [2:0]  tf_idx;
    logic [1:0]  alt_cs;
    logic        dma_chan;
    logic        ext_win_en;

    int errors = 0;
    int checks = 0;
    logic [7:0] s_rdata;
    logic [1:0] s_tf;
    logic [2:0] s_idx;
    logic [1:0] s_alt;

    ide_irq_router dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .drv_irq    (drv_irq),
        .host_irq   (host_irq),
        .tf_cs      (tf_cs),
        .tf_idx     (tf_idx),
        .alt_cs     (alt_cs),
        .dma_chan   (dma_chan),
        .ext_win_en (ext_win_en)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic do_wr, input logic do_rd,
                             input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = do_wr;
        bus_rd    = do_rd;
        #(PERIOD / 4);
        s_rdata = bus_rdata;
        s_tf    = tf_cs;
        s_idx   = tf_idx;
        s_alt   = alt_cs;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: both drives asserted during and after reset, enables must stay clear
        drv_irq = 2'b11;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        chk("R1 host_irq after reset", 8'(host_irq), 8'h0);
        chk("R1 dma_chan after reset", 8'(dma_chan), 8'h0);
        chk("R1 ext_win_en after reset", 8'(ext_win_en), 8'h0);
        chk("R6 tf_cs idle", 8'(tf_cs), 8'h0);
        chk("R10 rdata idle", bus_rdata, 8'h0);
        @(negedge clk);
        drv_irq = 2'b00;
        idle(3);

        for (int i = 0; i < NVEC; i++) begin
            logic [41:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            bus_cycle(v[41], !v[41], v[40:27], v[26:19]);
            if (!v[41]) chk({tag, " rdata"}, s_rdata, v[18:11]);
            chk({tag, " tf_cs"}, 8'(s_tf), 8'(v[10:9]));
            if (v[10:9] != 2'b00) chk({tag, " tf_idx"}, 8'(s_idx), 8'(v[8:6]));
            chk({tag, " alt_cs"}, 8'(s_alt), 8'(v[5:4]));
        end

        // R9 configuration outputs
        bus_cycle(1'b1, 1'b0, 14'h0000, 8'h21);
        chk("R9 dma_chan set", 8'(dma_chan), 8'h1);
        chk("R9 ext_win_en set", 8'(ext_win_en), 8'h1);
        bus_cycle(1'b1, 1'b0, 14'h0000, 8'h01);
        chk("R9 ext_win_en dropped", 8'(ext_win_en), 8'h0);
        chk("R9 dma_chan kept", 8'(dma_chan), 8'h1);
        bus_cycle(1'b1, 1'b0, 14'h0000, 8'h00);
        chk("R9 dma_chan cleared", 8'(dma_chan), 8'h0);

        // R5 pending without enable stays masked; R3 status visible anyway
        @(negedge clk);
        drv_irq = 2'b01;
        idle(3);
        chk("R5 masked pending", 8'(host_irq), 8'h0);
        bus_cycle(1'b0, 1'b1, 14'h2290, 8'h00);
        chk("R3 ch0 pending w/o enable", s_rdata, 8'h01);

        // R2 set by write of any value
        bus_cycle(1'b1, 1'b0, 14'h2200, 8'h00);
        chk("R2 ch0 enable set", 8'(host_irq), 8'h1);
        // R2 reading the other channel's address leaves ch0 alone
        bus_cycle(1'b0, 1'b1, 14'h3200, 8'h00);
        chk("R2 ch1 ctl read returns 0", s_rdata, 8'h00);
        chk("R2 ch0 untouched by ch1 read", 8'(host_irq), 8'h1);
        // R3 status read has no side effect
        bus_cycle(1'b0, 1'b1, 14'h2290, 8'h00);
        chk("R3 status read keeps enable", 8'(host_irq), 8'h1);
        // R2 read clears
        bus_cycle(1'b0, 1'b1, 14'h2200, 8'h00);
        chk("R2 ch0 ctl read returns 0", s_rdata, 8'h00);
        chk("R2 ch0 enable cleared", 8'(host_irq), 8'h0);
        bus_cycle(1'b0, 1'b1, 14'h2290, 8'h00);
        chk("R3 pending kept after clear", s_rdata, 8'h01);

        // R4 synchroniser latency, with ch0 enabled
        bus_cycle(1'b1, 1'b0, 14'h2200, 8'hA5);
        @(negedge clk);
        drv_irq = 2'b00;
        @(posedge clk); #1;
        chk("R4 fall after 1 edge", 8'(host_irq), 8'h1);
        @(posedge clk); #1;
        chk("R4 fall after 2 edges", 8'(host_irq), 8'h0);
        @(negedge clk);
        drv_irq = 2'b01;
        @(posedge clk); #1;
        chk("R4 rise after 1 edge", 8'(host_irq), 8'h0);
        @(posedge clk); #1;
        chk("R4 rise after 2 edges", 8'(host_irq), 8'h1);
        bus_cycle(1'b0, 1'b1, 14'h2200, 8'h00);

        // channel 1 path
        @(negedge clk);
        drv_irq = 2'b10;
        idle(3);
        bus_cycle(1'b0, 1'b1, 14'h3290, 8'h00);
        chk("R3 ch1 pending", s_rdata, 8'h01);
        bus_cycle(1'b0, 1'b1, 14'h2290, 8'h00);
        chk("R3 ch0 not pending", s_rdata, 8'h00);
        chk("R5 ch1 masked", 8'(host_irq), 8'h0);
        // R2 read and write together: write wins
        bus_cycle(1'b1, 1'b1, 14'h3200, 8'h00);
        chk("R2 write wins over read", 8'(host_irq), 8'h1);
        bus_cycle(1'b0, 1'b1, 14'h3200, 8'h00);
        chk("R2 ch1 enable cleared", 8'(host_irq), 8'h0);

        // R5 OR of both channels
        bus_cycle(1'b1, 1'b0, 14'h2200, 8'h00);
        chk("R5 ch0 enabled, only ch1 pending", 8'(host_irq), 8'h0);
        bus_cycle(1'b1, 1'b0, 14'h3200, 8'h00);
        chk("R5 ch1 enabled and pending", 8'(host_irq), 8'h1);
        @(negedge clk);
        drv_irq = 2'b00;
        idle(3);
        chk("R5 nothing pending", 8'(host_irq), 8'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule